// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address-Mark Wakeup

This block receives asynchronous serial characters on a shared multidrop line. Each character carries one start bit, eight data bits sent least significant bit first, a data-type bit and one stop bit. A type bit of 1 marks the character as an address and 0 marks it as data. The bit rate is fixed at one sixty-fourth of the block clock. Every bit is sampled sixteen times and decided by a majority vote over the three samples around its centre.

Software puts the receiver to sleep by pulsing `sleep_set`. While it sleeps, received characters are discarded and change nothing. Two wakeup modes are available through `wake_sel`. In address-mark mode (`wake_sel` = 1), a character whose type bit is 1 clears the sleep state and is delivered normally. In idle-line mode (`wake_sel` = 0), every character is discarded while asleep. A stretch of idle line of at least eleven bit times clears the sleep state, and the receiver then takes the next start bit as a new character. Hardware only ever clears the sleep state. Software has to set it again for every message it wants to skip.

A delivered character fills a one-entry holding register. The block reports its type bit, a framing error and an overrun. It raises either a normal receive request or an exception request, gated by `rie`. A `rd_ack` pulse marks the holding register as read and clears its status.

Top module: `mdrop_wake_rx`

## Requirements
- R1: A character is a low start bit, then data bits 0 through 7, then the type bit, then the stop bit, with 64 clock cycles per bit. When it is accepted, `rx_data` shows the data byte and `rx_addr` shows the type bit.
- R2: The start bit is confirmed by a majority vote near its centre. A low pulse of 12 clock cycles or less on an idle line starts no character and changes no output.
- R3: An accepted character whose stop bit is 0 sets `frame_err`. An accepted character with a stop bit of 1 leaves `frame_err` at 0.
- R4: If a character is accepted while `rx_full` is 1 and no `rd_ack` is given, `overrun` is set. `rx_data`, `rx_addr` and `frame_err` keep the values of the character already held.
- R5: A `rd_ack` pulse clears `rx_full`, `frame_err` and `overrun`.
- R6: While `sleep` is 1 in address-mark mode, a character with type bit 0 changes neither `rx_data`, `rx_addr`, `rx_full`, `frame_err`, `overrun` nor `sleep`.
- R7: While `sleep` is 1 in address-mark mode, a character with type bit 1 clears `sleep` and is accepted, which sets `rx_addr` to 1.
- R8: `sleep` rises only after a `sleep_set` pulse. It stays 0 across any number of characters until software sets it again.
- R9: While `sleep` is 1 in idle-line mode, every character is discarded. The line held high for at least 11 bit times with no character in progress clears `sleep`. The count of idle time restarts on `sleep_set` and on any low sample.
- R10: `irq_rx` equals `rie` and `rx_full` with neither `frame_err` nor `overrun`. `irq_rx_err` equals `rie` and `rx_full` with `frame_err` or `overrun`. The two are never high together.
- R11: After reset, `rx_full`, `frame_err`, `overrun`, `sleep`, `rx_addr`, both requests and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| wake_sel | input | 1 | 1: address-mark wakeup, 0: idle-line wakeup |
| sleep_set | input | 1 | One-cycle pulse that puts the receiver to sleep |
| rie | input | 1 | Receive request enable |
| rd_ack | input | 1 | One-cycle pulse: held character has been read |
| rx_data | output | 8 | Held data byte |
| rx_addr | output | 1 | Type bit of the held character |
| rx_full | output | 1 | Holding register contains an unread character |
| frame_err | output | 1 | Held character had a stop bit of 0 |
| overrun | output | 1 | A character arrived while the register was full |
| sleep | output | 1 | Receiver is asleep |
| irq_rx | output | 1 | Normal receive request |
| irq_rx_err | output | 1 | Receive-with-exception request |

## Verification
Random bytes are sent with both type-bit values, with a good or a bad stop bit, and with the receiver awake or asleep in either wakeup mode. This separates the discard rule for data characters in address-mark mode from the rule that discards every character in idle-line mode. Gaps after a character are either short, at about 2.5 bit times, or long, at about 15.5 bit times, so idle wakeup is told apart from an ordinary pause between characters. Unread characters followed by another character exercise the overrun path against the normal load. A short low glitch shows that a start bit which fails its mid-bit vote is rejected.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              addr;
    logic              stop_ok;
  } rx_frame_t;
endpackage

// File: rtl/mdrop_baud_tick.sv
module mdrop_baud_tick #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    tick_d = (cnt_q == LAST);
    cnt_d  = tick_d ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && (TICK_DIV > 1)) |=> !tick_q); // R1
endmodule

// File: rtl/mdrop_frame_rx.sv
module mdrop_frame_rx
  import mdrop_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  output logic      line_s,
  output logic      rx_idle,
  output logic      done,
  output rx_frame_t frame
);
  localparam int OW = $clog2(OSR);
  localparam logic [OW-1:0] MID = OW'(OSR / 2);
  localparam int NBITS = DATA_W + 3;
  localparam int IW = $clog2(NBITS);
  localparam logic [IW-1:0] IDX_TYPE = IW'(DATA_W + 1);
  localparam logic [IW-1:0] IDX_STOP = IW'(DATA_W + 2);

  logic              s1_q, s2_q;
  logic [1:0]        hist_q, hist_d;
  rx_state_e         st_q, st_d;
  logic [OW-1:0]     os_q, os_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] sr_q, sr_d;
  logic              typ_q, typ_d;
  logic              done_q, done_d;
  rx_frame_t         frm_q, frm_d;
  logic              vote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd;
      s2_q <= s1_q;
    end
  end

  assign vote = (hist_q[1] & hist_q[0]) | (hist_q[1] & s2_q) | (hist_q[0] & s2_q);

  always_comb begin
    hist_d = hist_q;
    st_d   = st_q;
    os_d   = os_q;
    idx_d  = idx_q;
    sr_d   = sr_q;
    typ_d  = typ_q;
    done_d = 1'b0;
    frm_d  = frm_q;
    if (tick) begin
      hist_d = {hist_q[0], s2_q};
      unique case (st_q)
        RX_IDLE: begin
          if (hist_q[0] && !s2_q) begin
            st_d  = RX_BUSY;
            os_d  = OW'(1);
            idx_d = '0;
          end
        end
        RX_BUSY: begin
          os_d = os_q + 1'b1;
          if (os_q == MID) begin
            idx_d = idx_q + 1'b1;
            if (idx_q == '0) begin
              if (vote) st_d = RX_IDLE;
            end else if (idx_q == IDX_TYPE) begin
              typ_d = vote;
            end else if (idx_q == IDX_STOP) begin
              st_d          = RX_IDLE;
              done_d        = 1'b1;
              frm_d.data    = sr_q;
              frm_d.addr    = typ_q;
              frm_d.stop_ok = vote;
            end else begin
              sr_d = {vote, sr_q[DATA_W-1:1]};
            end
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 2'b11;
      st_q   <= RX_IDLE;
      os_q   <= '0;
      idx_q  <= '0;
      sr_q   <= '0;
      typ_q  <= 1'b0;
      done_q <= 1'b0;
      frm_q  <= '0;
    end else begin
      hist_q <= hist_d;
      st_q   <= st_d;
      os_q   <= os_d;
      idx_q  <= idx_d;
      sr_q   <= sr_d;
      typ_q  <= typ_d;
      done_q <= done_d;
      frm_q  <= frm_d;
    end
  end

  assign line_s  = s2_q;
  assign rx_idle = (st_q == RX_IDLE);
  assign done    = done_q;
  assign frame   = frm_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R1
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(st_q == RX_BUSY)); // R2
endmodule

// File: rtl/mdrop_idle_det.sv
module mdrop_idle_det #(
  parameter int IDLE_TICKS = 176
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic rx_idle,
  input  logic restart,
  output logic idle_seen
);
  localparam int CW = $clog2(IDLE_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(IDLE_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (tick) begin
      if (!line || !rx_idle) cnt_d = '0;
      else if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign idle_seen = (cnt_q == FULL);

  AST_IDLE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_seen) |-> ($past(line) && $past(rx_idle) && !$past(restart))); // R9
endmodule

// File: rtl/mdrop_wake_rx.sv
module mdrop_wake_rx
  import mdrop_rx_pkg::*;
#(
  parameter int TICK_DIV   = 4,
  parameter int OSR        = 16,
  parameter int IDLE_BITS  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              wake_sel,
  input  logic              sleep_set,
  input  logic              rie,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_addr,
  output logic              rx_full,
  output logic              frame_err,
  output logic              overrun,
  output logic              sleep,
  output logic              irq_rx,
  output logic              irq_rx_err
);
  localparam int IDLE_TICKS = IDLE_BITS * OSR;

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic      tick, line_s, rx_idle, frm_done, idle_seen;
  rx_frame_t frm;

  mdrop_baud_tick #(.TICK_DIV(TICK_DIV)) u_baud (
    .clk   (clk),
    .rst_n (rst_n_i),
    .tick  (tick)
  );

  mdrop_frame_rx #(.OSR(OSR)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .tick    (tick),
    .rxd     (rxd),
    .line_s  (line_s),
    .rx_idle (rx_idle),
    .done    (frm_done),
    .frame   (frm)
  );

  mdrop_idle_det #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .tick      (tick),
    .line      (line_s),
    .rx_idle   (rx_idle),
    .restart   (sleep_set),
    .idle_seen (idle_seen)
  );

  logic              sleep_q, sleep_d;
  logic              full_q, full_d;
  logic              fe_q, fe_d;
  logic              or_q, or_d;
  logic              addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              accept, load, ovr;

  always_comb begin
    accept = frm_done && (!sleep_q || (wake_sel && frm.addr));
    load   = accept && (!full_q || rd_ack);
    ovr    = accept && full_q && !rd_ack;

    data_d = load ? frm.data : data_q;
    addr_d = load ? frm.addr : addr_q;

    if (load)        full_d = 1'b1;
    else if (rd_ack) full_d = 1'b0;
    else             full_d = full_q;

    if (load)        fe_d = !frm.stop_ok;
    else if (rd_ack) fe_d = 1'b0;
    else             fe_d = fe_q;

    if (load)        or_d = 1'b0;
    else if (ovr)    or_d = 1'b1;
    else if (rd_ack) or_d = 1'b0;
    else             or_d = or_q;

    if (sleep_set)                                       sleep_d = 1'b1;
    else if (sleep_q && accept)                          sleep_d = 1'b0;
    else if (sleep_q && !wake_sel && idle_seen)          sleep_d = 1'b0;
    else                                                 sleep_d = sleep_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sleep_q <= 1'b0;
      full_q  <= 1'b0;
      fe_q    <= 1'b0;
      or_q    <= 1'b0;
      addr_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      sleep_q <= sleep_d;
      full_q  <= full_d;
      fe_q    <= fe_d;
      or_q    <= or_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign rx_data    = data_q;
  assign rx_addr    = addr_q;
  assign rx_full    = full_q;
  assign frame_err  = fe_q;
  assign overrun    = or_q;
  assign sleep      = sleep_q;
  assign irq_rx     = rie && full_q && !(fe_q || or_q);
  assign irq_rx_err = rie && full_q && (fe_q || or_q);

  AST_ASLEEP_DROP: assert property (@(posedge clk) disable iff (!rst_n_i)
    (frm_done && sleep_q && wake_sel && !frm.addr && !rd_ack && !sleep_set)
      |=> ($stable(data_q) && $stable(full_q) && $stable(fe_q) && $stable(or_q)
           && $stable(addr_q) && sleep_q)); // R6
  AST_ADDR_WAKE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (frm_done && sleep_q && wake_sel && frm.addr && !sleep_set) |=> !sleep_q); // R7
  AST_SLEEP_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(sleep_q) |-> $past(sleep_set)); // R8
  AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n_i)
    (frm_done && !sleep_q && full_q && !rd_ack) |=> (or_q && $stable(data_q))); // R4
  AST_FE_SET: assert property (@(posedge clk) disable iff (!rst_n_i)
    (frm_done && !sleep_q && !full_q && !frm.stop_ok) |=> fe_q); // R3
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(irq_rx && irq_rx_err)); // R10
endmodule

// File: tb/mdrop_wake_rx_tb_top.sv
module mdrop_wake_rx_tb_top;
  localparam int BIT_CLK = 64;

  logic       clk, rst_n, rxd, wake_sel, sleep_set, rie, rd_ack;
  logic [7:0] rx_data;
  logic       rx_addr, rx_full, frame_err, overrun, sleep, irq_rx, irq_rx_err;

  mdrop_wake_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .wake_sel(wake_sel),
    .sleep_set(sleep_set), .rie(rie), .rd_ack(rd_ack),
    .rx_data(rx_data), .rx_addr(rx_addr), .rx_full(rx_full),
    .frame_err(frame_err), .overrun(overrun), .sleep(sleep),
    .irq_rx(irq_rx), .irq_rx_err(irq_rx_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] e_data;
  logic e_addr, e_full, e_fe, e_or, e_sleep;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic f_irq(input logic r, input logic f, input logic e1, input logic e2, input logic want_err);
    return r && f && ((e1 || e2) == want_err);
  endfunction

  task automatic check_all(input string tag);
    chk(tag, "rx_data", rx_data, e_data);
    chk(tag, "rx_addr", rx_addr, e_addr);
    chk(tag, "rx_full", rx_full, e_full);
    chk(tag, "frame_err", frame_err, e_fe);
    chk(tag, "overrun", overrun, e_or);
    chk(tag, "sleep", sleep, e_sleep);
    chk(tag, "irq_rx R10", irq_rx, f_irq(rie, e_full, e_fe, e_or, 1'b0));
    chk(tag, "irq_rx_err R10", irq_rx_err, f_irq(rie, e_full, e_fe, e_or, 1'b1));
  endtask

  task automatic hold(input int nbits);
    repeat (nbits * BIT_CLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic t, input logic s);
    rxd = 1'b0; hold(1);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; hold(1); end
    rxd = t; hold(1);
    rxd = s; hold(1);
    rxd = 1'b1;
  endtask

  task automatic model_frame(input logic [7:0] d, input logic t, input logic s);
    if (!e_sleep || (wake_sel && t)) begin
      e_sleep = 1'b0;
      if (e_full) e_or = 1'b1;
      else begin
        e_data = d; e_addr = t; e_full = 1'b1; e_fe = !s; e_or = 1'b0;
      end
    end
  endtask

  task automatic do_ack();
    @(negedge clk); rd_ack = 1'b1;
    @(negedge clk); rd_ack = 1'b0;
    e_full = 1'b0; e_fe = 1'b0; e_or = 1'b0;
  endtask

  task automatic do_sleep(input logic ws);
    @(negedge clk); wake_sel = ws; sleep_set = 1'b1;
    @(negedge clk); sleep_set = 1'b0;
    e_sleep = 1'b1;
  endtask

  task automatic frame_step(input logic [7:0] d, input logic t, input logic s, input string tag);
    send_frame(d, t, s);
    model_frame(d, t, s);
    hold(2);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rxd = 1'b1; wake_sel = 1'b1; sleep_set = 1'b0; rie = 1'b0; rd_ack = 1'b0;
    e_data = '0; e_addr = 1'b0; e_full = 1'b0; e_fe = 1'b0; e_or = 1'b0; e_sleep = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_all("R11 reset");

    rie = 1'b1;
    frame_step(8'hA5, 1'b0, 1'b1, "R1 first frame");
    frame_step(8'h3C, 1'b1, 1'b1, "R4 overrun");
    do_ack(); check_all("R5 ack");
    frame_step(8'h81, 1'b0, 1'b0, "R3 bad stop");
    do_ack();
    frame_step(8'h5A, 1'b0, 1'b1, "R3 good stop");
    do_ack();

    do_sleep(1'b1); check_all("R8 sleep set");
    frame_step(8'hC3, 1'b0, 1'b1, "R6 data ignored asleep");
    frame_step(8'h12, 1'b1, 1'b1, "R7 address wake");
    do_ack();
    frame_step(8'h77, 1'b0, 1'b1, "R8 stays awake");
    do_ack();

    rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
    hold(14); check_all("R2 glitch rejected");

    do_sleep(1'b0);
    frame_step(8'h99, 1'b1, 1'b1, "R9 idle mode discard");
    hold(4); check_all("R9 short idle");
    hold(10); e_sleep = 1'b0; check_all("R9 idle wake");
    frame_step(8'h44, 1'b0, 1'b1, "R9 after idle wake");
    do_ack();

    for (int it = 0; it < 40; it++) begin
      logic [7:0] d;
      logic t, s, lg;
      if ($urandom % 4 == 0) do_sleep(1'($urandom % 2));
      rie = 1'($urandom % 2);
      d = 8'($urandom);
      t = 1'($urandom % 2);
      s = (($urandom % 6) != 0);
      frame_step(d, t, s, "R1 random");
      if ($urandom % 3 != 0) do_ack();
      lg = ($urandom % 3 == 0);
      if (lg) begin
        hold(13);
        if (e_sleep && !wake_sel) e_sleep = 1'b0;
      end
      check_all("R9 random gap");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule